// File: doc/BRIEF.md
# Linked-Descriptor Copy Channel with 40-bit Addressing

This block is one memory-to-memory copy channel that reaches a 40-bit byte address space. Software places eight-word descriptors in memory on 32-byte boundaries, writes the pointer to the first one (its byte address shifted right by five) and sets the run bit. The channel then reads the descriptor over its word-wide memory master port, copies the requested number of bytes one 32-bit word per beat (a read of the source followed by a write of the destination), and moves on to the descriptor named by the link word. A zero link ends the chain. A link that leads back to an earlier descriptor makes the chain repeat until software stops it.

The same memory port carries the descriptor reads and the data beats. A request is held, unchanged, until the memory raises ready; read data is taken in the cycle that ready is high. A 32-bit register port lets software start, stop and abort the channel, clear the completion and interrupt flags, and watch the live source, destination and remaining length. An interrupt output follows the interrupt flag.

Descriptor word order (word offset within the block): 0 control (bit 0 = interrupt when this block ends), 1 source address bits 31:0, 2 source extension (bits 7:0 = address bits 39:32, bit 12 = increment), 3 destination address bits 31:0, 4 destination extension (same layout), 5 length in bytes, 6 link pointer, 7 unused. Extension bits 14:13 (access width) and 11:8 (burst length minus one) are accepted but the datapath always moves one 32-bit word per beat.

Top module: `dma40_chan`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0, irq is low and no memory request is made.
- R2: Writing the status register with bit 0 = 1 while idle starts the channel: it reads eight consecutive words from byte address pointer*32, the pointer being the value in the register at offset 0x04.
- R3: Each block runs ceil(length/4) beats; each beat reads the source word then writes that word to the destination, with the 40-bit address formed from extension bits 7:0 above the 32-bit low word.
- R4: With extension bit 12 set a side's address steps by 4 after every beat; with it clear that side keeps one address.
- R5: A nonzero link makes the channel fetch the next block from link*32; a zero link sets END (status bit 1) and clears ACTIVE (bit 0); the pointer register then reads the zero link.
- R6: A chain whose last link points back to its first block keeps running with ACTIVE set until software stops it.
- R7: A block whose control bit 0 is set raises INT (status bit 2) when it ends; irq follows INT and stays high until 1 is written to status bit 2; END is cleared likewise through bit 1.
- R8: Writing status bit 30 while running lets the beat in progress finish, skips the rest of that block, and continues with its link.
- R9: Writing the status register with bit 0 = 0 (and bit 30 = 0) while running stops the channel after its pending write; ACTIVE reads 0, END stays 0 and offset 0x18 keeps the bytes not moved.
- R10: A block whose length exceeds 2^30 bytes moves no data, sets the error flag (status bit 10) and clears ACTIVE; the next start clears the flag.
- R11: Offsets 0x08/0x10 read the live source/destination low address and 0x0C/0x14 read the extension (bits 7:0 upper address, bit 12 increment).
- R12: Status bit 7 reads 1 while a destination write is presented and not yet accepted.
- R13: A block of length zero moves no data and the chain continues with its link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| irq | output | 1 | Interrupt, high while INT is set |

## Verification
A memory handshake takes effect on the clock edge where request and ready are both high, so the bench decides ready half a cycle early and compares each accepted request against its expected traffic queue at that point. The first descriptor read is presented one cycle after the edge that takes the start write, and status flags, live addresses and the remaining length appear on reg_rdata one cycle after the offset is driven, so each register check reads at the falling edge after that. Stop, abort and write-wait cases freeze the memory at a known handshake count, so the pending state they act on is fixed before the control write is made.

// File: rtl/dma40_pkg.sv
package dma40_pkg;
  localparam int WORD_W    = 32;
  localparam int WORD_B    = WORD_W / 8;

  // descriptor word slots
  localparam int CBW_CTRL  = 0;
  localparam int CBW_SLO   = 1;
  localparam int CBW_SEXT  = 2;
  localparam int CBW_DLO   = 3;
  localparam int CBW_DEXT  = 4;
  localparam int CBW_LEN   = 5;
  localparam int CBW_LINK  = 6;

  // status/control bits
  localparam int ST_RUN    = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_INT    = 2;
  localparam int ST_WAITW  = 7;
  localparam int ST_ERR    = 10;
  localparam int ST_ABORT  = 30;
  localparam int ST_HALT   = 31;

  localparam int CTL_IRQEN = 0;
  localparam int EXT_INC   = 12;

  // register word indices
  localparam logic [2:0] RG_STAT = 3'd0;
  localparam logic [2:0] RG_PTR  = 3'd1;
  localparam logic [2:0] RG_SLO  = 3'd2;
  localparam logic [2:0] RG_SEXT = 3'd3;
  localparam logic [2:0] RG_DLO  = 3'd4;
  localparam logic [2:0] RG_DEXT = 3'd5;
  localparam logic [2:0] RG_LEN  = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_BLKEND
  } eng_state_t;
endpackage

// File: rtl/dma40_addr_ctr.sv
module dma40_addr_ctr #(
  parameter int ADDR_W = 40,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              load_inc,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              inc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      inc  <= 1'b0;
    end else if (load) begin
      addr <= load_val;
      inc  <= load_inc;
    end else if (step && inc) begin
      addr <= addr + ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/dma40_desc_store.sv
module dma40_desc_store #(
  parameter int W     = 32,
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [W-1:0]       wdata,
  output logic [WORDS*W-1:0] words
);
  logic [W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_out
    assign words[g*W +: W] = store[g];
  end
endmodule

// File: rtl/dma40_engine.sv
module dma40_engine
  import dma40_pkg::*;
#(
  parameter int          ADDR_W    = 40,
  parameter int          CB_WORDS  = 8,
  parameter logic [31:0] LEN_LIMIT = 32'h4000_0000,
  localparam int IDX_W    = $clog2(CB_WORDS),
  localparam int CB_SHIFT = $clog2(CB_WORDS * WORD_B),
  localparam int HI_W     = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop_req,
  input  logic              abort_req,
  input  logic [WORD_W-1:0] cb_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              active,
  output logic              waitw,
  output logic              done_set,
  output logic              irq_set,
  output logic              err_set,
  output logic              ptr_upd,
  output logic [WORD_W-1:0] ptr_val,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              src_inc,
  output logic              dst_inc,
  output logic [WORD_W-1:0] rem_len
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(CB_WORDS - 1);
  localparam logic [WORD_W-1:0] BEAT_B   = WORD_W'(WORD_B);

  eng_state_t          st;
  logic [IDX_W-1:0]    fidx;
  logic [ADDR_W-1:0]   cb_addr;
  logic [WORD_W-1:0]   rem_q;
  logic [WORD_W-1:0]   data_q;
  logic                abort_pend;
  logic                stop_pend;
  logic [CB_WORDS*WORD_W-1:0] desc;

  logic [WORD_W-1:0] d_ctrl, d_slo, d_sext, d_dlo, d_dext, d_len, d_link;
  assign d_ctrl = desc[CBW_CTRL*WORD_W +: WORD_W];
  assign d_slo  = desc[CBW_SLO *WORD_W +: WORD_W];
  assign d_sext = desc[CBW_SEXT*WORD_W +: WORD_W];
  assign d_dlo  = desc[CBW_DLO *WORD_W +: WORD_W];
  assign d_dext = desc[CBW_DEXT*WORD_W +: WORD_W];
  assign d_len  = desc[CBW_LEN *WORD_W +: WORD_W];
  assign d_link = desc[CBW_LINK*WORD_W +: WORD_W];

  function automatic logic [ADDR_W-1:0] ptr2addr(input logic [WORD_W-1:0] p);
    return ADDR_W'({p, {CB_SHIFT{1'b0}}});
  endfunction

  logic len_bad, fetch_hs, beat_done;
  assign len_bad   = d_len > LEN_LIMIT;
  assign fetch_hs  = (st == S_FETCH) && mem_ready;
  assign beat_done = (st == S_WRITE) && mem_ready;

  dma40_desc_store #(.W(WORD_W), .WORDS(CB_WORDS)) u_desc (
    .clk   (clk),
    .we    (fetch_hs),
    .widx  (fidx),
    .wdata (mem_rdata),
    .words (desc)
  );

  dma40_addr_ctr #(.ADDR_W(ADDR_W), .STEP(WORD_B)) u_src (
    .clk      (clk),
    .rst      (rst),
    .load     (st == S_CHECK),
    .load_val ({d_sext[HI_W-1:0], d_slo}),
    .load_inc (d_sext[EXT_INC]),
    .step     (beat_done),
    .addr     (src_addr),
    .inc      (src_inc)
  );

  dma40_addr_ctr #(.ADDR_W(ADDR_W), .STEP(WORD_B)) u_dst (
    .clk      (clk),
    .rst      (rst),
    .load     (st == S_CHECK),
    .load_val ({d_dext[HI_W-1:0], d_dlo}),
    .load_inc (d_dext[EXT_INC]),
    .step     (beat_done),
    .addr     (dst_addr),
    .inc      (dst_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      fidx       <= '0;
      cb_addr    <= '0;
      rem_q      <= '0;
      data_q     <= '0;
      abort_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      if (st != S_IDLE) begin
        if (abort_req) abort_pend <= 1'b1;
        if (stop_req)  stop_pend  <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          if (start) begin
            cb_addr    <= ptr2addr(cb_ptr);
            fidx       <= '0;
            abort_pend <= 1'b0;
            stop_pend  <= 1'b0;
            st         <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ready) begin
            if (fidx == LAST_IDX) st <= S_CHECK;
            else fidx <= fidx + 1'b1;
          end
        end
        S_CHECK: begin
          rem_q <= d_len;
          if (stop_pend || len_bad)          st <= S_IDLE;
          else if (abort_pend || d_len == 0) st <= S_BLKEND;
          else                               st <= S_READ;
        end
        S_READ: begin
          if (mem_ready) begin
            data_q <= mem_rdata;
            st     <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (mem_ready) begin
            rem_q <= (rem_q > BEAT_B) ? rem_q - BEAT_B : '0;
            if (stop_pend)                         st <= S_IDLE;
            else if (rem_q <= BEAT_B || abort_pend) st <= S_BLKEND;
            else                                   st <= S_READ;
          end
        end
        S_BLKEND: begin
          abort_pend <= 1'b0;
          if (stop_pend || d_link == 0) begin
            st <= S_IDLE;
          end else begin
            cb_addr <= ptr2addr(d_link);
            fidx    <= '0;
            st      <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req = (st == S_FETCH) || (st == S_READ) || (st == S_WRITE);
    mem_we  = (st == S_WRITE);
    case (st)
      S_FETCH: mem_addr = cb_addr + ADDR_W'({fidx, 2'b00});
      S_READ:  mem_addr = src_addr;
      default: mem_addr = dst_addr;
    endcase
  end

  assign mem_wdata = data_q;
  assign active    = (st != S_IDLE);
  assign waitw     = (st == S_WRITE);
  assign done_set  = (st == S_BLKEND) && !stop_pend && (d_link == 0);
  assign irq_set   = (st == S_BLKEND) && d_ctrl[CTL_IRQEN];
  assign err_set   = (st == S_CHECK) && !stop_pend && len_bad;
  assign ptr_upd   = (st == S_BLKEND) && !stop_pend;
  assign ptr_val   = d_link;
  assign rem_len   = rem_q;

  logic unused_bits;
  assign unused_bits = ^{d_sext[WORD_W-1:HI_W], d_dext[WORD_W-1:HI_W],
                         d_ctrl[WORD_W-1:1], desc[CB_WORDS*WORD_W-1:(CBW_LINK+1)*WORD_W]};
endmodule

// File: rtl/dma40_chan.sv
module dma40_chan
  import dma40_pkg::*;
#(
  parameter int          ADDR_W    = 40,
  parameter int          CB_WORDS  = 8,
  parameter int          REG_AW    = 5,
  parameter logic [31:0] LEN_LIMIT = 32'h4000_0000,
  localparam int HI_W = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              irq
);
  logic [2:0] ridx;
  assign ridx = reg_addr[4:2];

  logic active, waitw, done_set, irq_set, err_set, ptr_upd;
  logic [31:0] ptr_val, rem_len;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic src_inc, dst_inc;
  logic done_q, irq_q, err_q;
  logic [31:0] ptr_q;

  logic stat_wr, start, stop_req, abort_req;
  assign stat_wr   = reg_we && (ridx == RG_STAT);
  assign start     = stat_wr && reg_wdata[ST_RUN] && !active;
  assign stop_req  = stat_wr && active &&
                     ((!reg_wdata[ST_RUN] && !reg_wdata[ST_ABORT]) || reg_wdata[ST_HALT]);
  assign abort_req = stat_wr && active && reg_wdata[ST_ABORT];

  dma40_engine #(
    .ADDR_W(ADDR_W), .CB_WORDS(CB_WORDS), .LEN_LIMIT(LEN_LIMIT)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop_req  (stop_req),
    .abort_req (abort_req),
    .cb_ptr    (ptr_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .active    (active),
    .waitw     (waitw),
    .done_set  (done_set),
    .irq_set   (irq_set),
    .err_set   (err_set),
    .ptr_upd   (ptr_upd),
    .ptr_val   (ptr_val),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .src_inc   (src_inc),
    .dst_inc   (dst_inc),
    .rem_len   (rem_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (done_set) done_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_DONE]) done_q <= 1'b0;
      if (irq_set) irq_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_INT]) irq_q <= 1'b0;
      if (err_set) err_q <= 1'b1;
      else if (start) err_q <= 1'b0;
      if (ptr_upd) ptr_q <= ptr_val;
      else if (reg_we && ridx == RG_PTR && !active) ptr_q <= reg_wdata;
    end
  end

  logic [31:0] stat_rd, sext_rd, dext_rd;
  always_comb begin
    stat_rd = '0;
    stat_rd[ST_RUN]   = active;
    stat_rd[ST_DONE]  = done_q;
    stat_rd[ST_INT]   = irq_q;
    stat_rd[ST_WAITW] = waitw;
    stat_rd[ST_ERR]   = err_q;
    sext_rd = '0;
    sext_rd[HI_W-1:0] = src_addr[ADDR_W-1:WORD_W];
    sext_rd[EXT_INC]  = src_inc;
    dext_rd = '0;
    dext_rd[HI_W-1:0] = dst_addr[ADDR_W-1:WORD_W];
    dext_rd[EXT_INC]  = dst_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (ridx)
        RG_STAT: reg_rdata <= stat_rd;
        RG_PTR:  reg_rdata <= ptr_q;
        RG_SLO:  reg_rdata <= src_addr[WORD_W-1:0];
        RG_SEXT: reg_rdata <= sext_rd;
        RG_DLO:  reg_rdata <= dst_addr[WORD_W-1:0];
        RG_DEXT: reg_rdata <= dext_rd;
        RG_LEN:  reg_rdata <= rem_len;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_q;

  logic unused_addr;
  assign unused_addr = ^reg_addr[1:0];
endmodule

// File: rtl/dma40_chan_chk.sv
module dma40_chan_chk #(
  parameter int ADDR_W = 40,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              irq,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              active,
  input logic              done_q,
  input logic              err_q
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mem_req && !irq));

  assert_word_align_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_end_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> !active);

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_we && reg_addr[REG_AW-1:2] == 3'd0 && reg_wdata[2])) |=> irq);

  assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> !active);
endmodule

bind dma40_chan dma40_chan_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .irq       (irq),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .active    (active),
  .done_q    (done_q),
  .err_q     (err_q)
);

// File: tb/tb_dma40_chan.sv
module tb_dma40_chan;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma40_chan dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
  );

  logic [31:0] mem [1024];
  logic [AW-1:0] q_addr[$];
  logic          q_we[$];
  logic [31:0]   q_data[$];
  string         q_tag[$];

  int compared = 0, mismatched = 0, hs_cnt = 0, stall_at = -1, ncyc = 0, pcyc = 0;
  logic [31:0] v;
  int nxt;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // memory responder and traffic comparison, one decision per falling edge
  always @(negedge clk) begin
    logic rdy;
    ncyc++;
    rdy = !(stall_at >= 0 && hs_cnt == stall_at) && (ncyc % 4 != 3);
    mem_ready = rdy;
    mem_rdata = mem[mem_addr[11:2]];
    if (rst) begin
      if (mem_req) check("R1 request during reset", 1, 0);
    end else if (mem_req && rdy) begin
      hs_cnt++;
      if (q_addr.size() == 0) begin
        check("R1 unexpected request", {24'd0, mem_addr}, 64'hFFFF);
      end else begin
        string t;
        logic [AW-1:0] ea;
        logic ew;
        logic [31:0] ed;
        t = q_tag.pop_front(); ea = q_addr.pop_front();
        ew = q_we.pop_front(); ed = q_data.pop_front();
        check({t, " address"}, mem_addr, ea);
        check({t, " direction"}, mem_we, ew);
        if (ew) check({t, " write data"}, mem_wdata, ed);
      end
      if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
    end
  end

  always @(posedge clk) begin
    pcyc++;
    if (pcyc > 100000) begin
      check("watchdog expired", 1, 0);
      summary();
      $finish;
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 5'(idx * 4); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = 5'(idx * 4);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(0, s);
      if (!s[0]) return;
    end
    check("channel never went idle", 1, 0);
  endtask

  task automatic set_desc(input int p, input logic [31:0] ctl, slo, sext,
                          dlo, dext, len, link);
    mem[p*8+0] = ctl;  mem[p*8+1] = slo; mem[p*8+2] = sext;
    mem[p*8+3] = dlo;  mem[p*8+4] = dext; mem[p*8+5] = len;
    mem[p*8+6] = link; mem[p*8+7] = 32'hDEAD_0007;
  endtask

  task automatic push(string t, logic [AW-1:0] a, logic w, logic [31:0] d);
    q_tag.push_back(t); q_addr.push_back(a); q_we.push_back(w); q_data.push_back(d);
  endtask

  // expected traffic of one block: descriptor fetch, then up to max_beats beats
  task automatic push_block(input int p, input string ftag, input int max_beats,
                            output int link);
    logic [AW-1:0] s, d;
    longint len, beats;
    for (int k = 0; k < 8; k++) push({ftag, " descriptor fetch"}, AW'(p*32 + k*4), 1'b0, 0);
    s = {mem[p*8+2][7:0], mem[p*8+1]};
    d = {mem[p*8+4][7:0], mem[p*8+3]};
    len = longint'(mem[p*8+5]);
    beats = (len > 64'h4000_0000) ? 0 : (len + 3) / 4;
    if (beats > max_beats) beats = max_beats;
    for (int b = 0; b < beats; b++) begin
      logic [AW-1:0] sa, da;
      sa = s + (mem[p*8+2][12] ? AW'(4*b) : '0);
      da = d + (mem[p*8+4][12] ? AW'(4*b) : '0);
      push("R3 beat read (R4 step)", sa, 1'b0, 0);
      push("R3 beat write (R4 step)", da, 1'b1, mem[sa[11:2]]);
    end
    link = int'(mem[p*8+6]);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
    mem_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(0, v); check("R1 status after reset", v, 0);
    check("R1 irq after reset", irq, 0);

    // single block, source increments, fixed destination, irq enabled
    set_desc(1, 32'h1, 32'h200, 32'h0000_5F04, 32'h300, 32'h0000_0002, 16, 0);
    push_block(1, "R2", 1000, nxt);
    wr(1, 1); hs_cnt = 0; wr(0, 1);
    wait_idle();
    check("R3 all traffic of single block seen", q_addr.size(), 0);
    rd(0, v); check("R5/R7 END and INT after single block", v, 32'h6);
    check("R7 irq high", irq, 1);
    rd(2, v); check("R11 live source low", v, 32'h210);
    rd(3, v); check("R11 source extension", v, 32'h1004);
    rd(4, v); check("R4 fixed destination", v, 32'h300);
    rd(5, v); check("R11 destination extension", v, 32'h0002);
    rd(6, v); check("R3 remaining length", v, 0);
    rd(1, v); check("R5 pointer holds zero link", v, 0);
    wr(0, 32'h6);
    check("R7 irq cleared by write", irq, 0);
    rd(0, v); check("R7 END and INT cleared", v, 0);

    // three-block chain with a zero-length block and an odd length
    set_desc(2, 32'h0, 32'h400, 32'h0000_1001, 32'h500, 32'h0000_1003, 12, 3);
    set_desc(3, 32'h0, 32'h480, 32'h0000_1001, 32'h580, 32'h0000_1003, 0, 4);
    set_desc(4, 32'h0, 32'h600, 32'h0000_1005, 32'h700, 32'h0000_1006, 6, 0);
    push_block(2, "R2", 1000, nxt);
    push_block(3, "R5 R13", 1000, nxt);
    push_block(4, "R5", 1000, nxt);
    wr(1, 2); wr(0, 1);
    wait_idle();
    check("R5 R13 all chain traffic seen", q_addr.size(), 0);
    rd(0, v); check("R5 END only, no INT", v, 32'h2);
    rd(4, v); check("R11 destination after odd length", v, 32'h708);
    rd(5, v); check("R11 destination extension chain", v, 32'h1006);
    wr(0, 32'h2);

    // oversize length
    set_desc(5, 32'h1, 32'hA80, 32'h0000_1000, 32'hAC0, 32'h0000_1000, 32'h4000_0001, 0);
    push_block(5, "R10", 1000, nxt);
    wr(1, 5); wr(0, 1);
    wait_idle();
    check("R10 no data moved", q_addr.size(), 0);
    rd(0, v); check("R10 error flag, no END", v, 32'h400);
    check("R10 no irq", irq, 0);

    // abort in the middle of a block
    set_desc(6, 32'h0, 32'h800, 32'h0000_1000, 32'h900, 32'h0000_1000, 32, 7);
    set_desc(7, 32'h1, 32'hA00, 32'h0000_1000, 32'hB00, 32'h0000_1000, 8, 0);
    push_block(6, "R2", 3, nxt);
    push_block(7, "R8", 1000, nxt);
    wr(1, 6); hs_cnt = 0; stall_at = 12; wr(0, 1);
    while (hs_cnt != 12) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(0, 32'h4000_0001);
    stall_at = -1;
    wait_idle();
    check("R8 block cut short, chain continued", q_addr.size(), 0);
    rd(0, v); check("R8 R10 END and INT, error cleared by start", v, 32'h6);
    wr(0, 32'h6);
    check("R7 irq cleared after abort run", irq, 0);

    // stop while a write waits for the memory
    set_desc(8, 32'h0, 32'hC00, 32'h0000_1000, 32'hD00, 32'h0000_1000, 16, 0);
    push_block(8, "R9", 1, nxt);
    wr(1, 8); hs_cnt = 0; stall_at = 9; wr(0, 1);
    while (hs_cnt != 9) @(negedge clk);
    repeat (3) @(negedge clk);
    rd(0, v); check("R12 waiting-for-write flag", v, 32'h81);
    wr(0, 32'h0);
    stall_at = -1;
    wait_idle();
    check("R9 stopped after pending write", q_addr.size(), 0);
    rd(0, v); check("R9 stopped without END", v, 0);
    rd(6, v); check("R9 remaining length kept", v, 12);
    rd(2, v); check("R9 source position kept", v, 32'hC04);

    // cyclic chain A -> B -> A
    set_desc(9,  32'h0, 32'hE00, 32'h0000_1000, 32'hF00, 32'h0000_1000, 8, 10);
    set_desc(10, 32'h0, 32'hE40, 32'h0000_1000, 32'hF40, 32'h0000_1000, 4, 9);
    for (int r = 0; r < 2; r++) begin
      push_block(9, "R6", 1000, nxt);
      push_block(10, "R6", 1000, nxt);
    end
    push_block(9, "R6", 1, nxt);
    wr(1, 9); hs_cnt = 0; stall_at = 52; wr(0, 1);
    while (hs_cnt != 52) @(negedge clk);
    repeat (3) @(negedge clk);
    rd(0, v); check("R6 still active after wrapping twice", v[0], 1);
    check("R6 no END on cyclic chain", v[1], 0);
    wr(0, 32'h0);
    stall_at = -1;
    wait_idle();
    check("R6 R9 cyclic traffic then stop", q_addr.size(), 0);
    rd(0, v); check("R9 cyclic stop leaves status clear", v, 0);

    summary();
    $finish;
  end
endmodule